// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block gives a host processor three 8-bit parallel ports, A, B and C, behind a byte-wide bus. The bus has a 2-bit address and active-low read and write strobes. Writes to the control address either program the port directions and modes, or set or clear one port C bit. Each port uses separate input and output buses with output enables, so a pad ring can build the tristate pins outside the block.

In simple mode every port, and each 4-bit half of port C, is an input or an output of its own. In strobed mode, ports A and B each run a handshake with a peripheral. Some port C pins then carry fixed strobe, acknowledge, buffer-full and interrupt-request lines. An input port latches its pins when its strobe goes low. An output port flags new data until the peripheral acknowledges it. The strobe and acknowledge pins pass through a configurable synchronizer. Host strobes act on their rising edge, sampled in the block's clock domain.

Top module: `ppio_top`

## Requirements
- R1: Address 0 selects port A, 1 selects port B, 2 selects port C and 3 the control register. A read of address 3 returns 0x00. `d_oe` is high exactly while `rd_n` is low.
- R2: After reset all three ports are inputs in simple mode, every output enable is low, the port C latch is 0x00, and port A/B reads return the pins.
- R3: A control write with bit 7 set and bit 6 clear programs the configuration: bit 5 is port A strobed mode, bit 4 is port A input, bit 3 is port C upper half input, bit 2 is port B strobed mode, bit 1 is port B input and bit 0 is port C lower half input. 0x98 gives A in, C upper in, B out, C lower out. 0x80 makes every port an output.
- R4: In simple mode a write to an output port drives its output bus from the edge after the write strobe rises. A read returns the latch for output ports and halves, and the pins for input ones.
- R5: A control write with bit 7 clear sets port C latch bit bits[3:1] to the value of bit 0 (0x09 sets bit 4, 0x08 clears it). No other latch bit and no configuration changes.
- R6: Every accepted configuration write clears the port A, B and C output latches, the buffer-full and acknowledge flags, and so the interrupt enables.
- R7: A control write with bits 7 and 6 both set (bidirectional mode) is ignored: configuration and all latches keep their values.
- R8: With port A in strobed input mode, C4 is the active-low strobe input, C5 the input-buffer-full output and C3 the interrupt request. A low strobe latches the port A pins and sets C5. A port A read returns the latched byte, and the rising edge of that read clears C5.
- R9: With port B in strobed input mode, C2 is the strobe input, C1 input-buffer-full and C0 the interrupt request, with the same behaviour as R8.
- R10: With port A in strobed output mode, C7 is the active-low output-buffer-full and C6 the active-low acknowledge input. A port A write drives C7 low. An acknowledge while C7 is low releases C7 high.
- R11: With port B in strobed output mode, C1 is the active-low output-buffer-full and C2 the acknowledge input, with the same behaviour as R10.
- R12: An interrupt request is high only while its enable latch bit is 1: C4 for port A input, C6 for port A output, C2 for port B. For an input port it follows input-buffer-full. For an output port it rises when an acknowledge releases the buffer and falls on the next write to that port.
- R13: In strobed mode a port C read returns the buffer-full and interrupt states at their bit positions, and the enable latch bit at a strobe or acknowledge position. Other bits follow R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select |
| rd_n | input | 1 | Active-low host read strobe |
| wr_n | input | 1 | Active-low host write strobe |
| d_in | input | 8 | Host write data |
| d_out | output | 8 | Host read data |
| d_oe | output | 1 | Host data bus drive enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
A host write takes effect on the clock edge after `wr_n` rises. The bench holds the strobe low for one full cycle, raises it on a falling edge, and samples one falling edge later. Read data is combinational and is sampled 1 ns after `rd_n` falls. A buffer-full flag cleared by a read is checked two falling edges after `rd_n` rises. A strobe or acknowledge pulse reaches the flags `SYNC_STAGES` + 1 edges after it is driven. The bench holds each pulse, and waits after its release, for `SYNC_STAGES` + 2 cycles before it checks the flags.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

   localparam int unsigned DW = 8;

   localparam logic [1:0] SEL_PA  = 2'd0;
   localparam logic [1:0] SEL_PB  = 2'd1;
   localparam logic [1:0] SEL_PC  = 2'd2;
   localparam logic [1:0] SEL_CTL = 2'd3;

   // port C handshake positions; peripherals wire to these
   localparam int unsigned PC_INTR_B = 0;
   localparam int unsigned PC_FLAG_B = 1;
   localparam int unsigned PC_STRB_B = 2;
   localparam int unsigned PC_INTR_A = 3;
   localparam int unsigned PC_STB_A  = 4;
   localparam int unsigned PC_IBF_A  = 5;
   localparam int unsigned PC_ACK_A  = 6;
   localparam int unsigned PC_OBF_A  = 7;

   typedef struct packed {
      logic a_m1;
      logic a_in;
      logic cu_in;
      logic b_m1;
      logic b_in;
      logic cl_in;
   } ppio_cfg_t;

   function automatic ppio_cfg_t cw_decode(input logic [DW-1:0] cw);
      ppio_cfg_t c;
      c.a_m1  = cw[5];
      c.a_in  = cw[4];
      c.cu_in = cw[3];
      c.b_m1  = cw[2];
      c.b_in  = cw[1];
      c.cl_in = cw[0];
      return c;
   endfunction

endpackage

// File: rtl/ppio_bus_edge.sv
module ppio_bus_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_n,
   input  logic wr_n,
   output logic rd_rise,
   output logic wr_rise
);
   logic rd_q;
   logic wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= 1'b1;
         wr_q <= 1'b1;
      end else begin
         rd_q <= rd_n;
         wr_q <= wr_n;
      end
   end

   assign rd_rise = rd_n & ~rd_q;
   assign wr_rise = wr_n & ~wr_q;

endmodule

// File: rtl/ppio_sync.sv
module ppio_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < int'(STAGES); i++) begin
                  sh[i] <= sh[i-1];
               end
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ppio_cfg.sv
module ppio_cfg
   import ppio_pkg::*;
#(
   parameter logic [DW-1:0] RESET_CW = 8'h9B
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cw_wr,
   input  logic          pc_wr,
   input  logic [DW-1:0] wdata,
   output ppio_cfg_t     cfg_q,
   output logic [DW-1:0] pc_lat,
   output logic          mode_set
);
   logic bsr_cmd;

   assign mode_set = cw_wr & wdata[7] & ~wdata[6];
   assign bsr_cmd  = cw_wr & ~wdata[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= cw_decode(RESET_CW);
         pc_lat <= '0;
      end else if (mode_set) begin
         cfg_q  <= cw_decode(wdata);
         pc_lat <= '0;
      end else if (bsr_cmd) begin
         pc_lat[wdata[3:1]] <= wdata[0];
      end else if (pc_wr) begin
         pc_lat <= wdata;
      end
   end

   // R5
   bsr_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && !wdata[7]) |=> (pc_lat[$past(wdata[3:1])] == $past(wdata[0])));

   // R5
   bsr_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && !wdata[7]) |=> $stable(cfg_q));

   // R7
   mode2_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && wdata[7] && wdata[6] && !pc_wr) |=> ($stable(cfg_q) && $stable(pc_lat)));

   // R6
   pc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && wdata[7] && !wdata[6]) |=> (pc_lat == '0));

endmodule

// File: rtl/ppio_hs_chan.sv
module ppio_hs_chan #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         mode1,
   input  logic         is_input,
   input  logic         inte,
   input  logic         sa_n,
   input  logic         host_wr,
   input  logic         host_rd,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] pins,
   output logic [W-1:0] out_lat,
   output logic [W-1:0] in_lat,
   output logic         ibf,
   output logic         obf_n,
   output logic         intr
);
   logic obf_q;
   logic ack_done;
   logic hs_out;
   logic hs_in;

   assign hs_out = mode1 & ~is_input;
   assign hs_in  = mode1 & is_input;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_lat  <= '0;
         in_lat   <= '0;
         ibf      <= 1'b0;
         obf_q    <= 1'b0;
         ack_done <= 1'b0;
      end else if (clr) begin
         out_lat  <= '0;
         in_lat   <= '0;
         ibf      <= 1'b0;
         obf_q    <= 1'b0;
         ack_done <= 1'b0;
      end else begin
         if (host_wr) begin
            out_lat <= wdata;
            if (hs_out) begin
               obf_q    <= 1'b1;
               ack_done <= 1'b0;
            end
         end else if (hs_out && !sa_n && obf_q) begin
            obf_q    <= 1'b0;
            ack_done <= 1'b1;
         end
         if (hs_in && !sa_n) begin
            in_lat <= pins;
            ibf    <= 1'b1;
         end else if (hs_in && host_rd) begin
            ibf <= 1'b0;
         end
      end
   end

   assign obf_n = ~obf_q;
   assign intr  = mode1 & inte & (is_input ? ibf : ack_done);

   // R8
   ibf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_in && !sa_n && !clr) |=> ibf);

   // R10
   obf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && hs_out && !clr) |=> !obf_n);

   // R6
   clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!ibf && obf_n && (out_lat == '0)));

endmodule

// File: rtl/ppio_top.sv
module ppio_top
   import ppio_pkg::*;
#(
   parameter int unsigned     SYNC_STAGES = 2,
   parameter logic [DW-1:0]   RESET_CW    = 8'h9B
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    addr,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [DW-1:0] d_in,
   output logic [DW-1:0] d_out,
   output logic          d_oe,
   input  logic [DW-1:0] pa_in,
   output logic [DW-1:0] pa_out,
   output logic          pa_oe,
   input  logic [DW-1:0] pb_in,
   output logic [DW-1:0] pb_out,
   output logic          pb_oe,
   input  logic [DW-1:0] pc_in,
   output logic [DW-1:0] pc_out,
   output logic [DW-1:0] pc_oe
);
   localparam int unsigned NCH = 2;

   generate
      if (SYNC_STAGES > 3) begin : g_bad_sync
         $error("ppio_top: SYNC_STAGES above 3 is not supported");
      end
      if ((RESET_CW[7] != 1'b1) || (RESET_CW[6] != 1'b0)) begin : g_bad_cw
         $error("ppio_top: RESET_CW must be a mode-set word without bidirectional mode");
      end
   endgenerate

   logic          rd_rise, wr_rise;
   logic          cw_wr, pc_wr, mode_set;
   ppio_cfg_t     cfg;
   logic [DW-1:0] pc_lat;
   logic [DW-1:0] pc_rd;

   logic [NCH-1:0] ch_m1, ch_in, ch_inte, ch_sa_raw, ch_sa;
   logic [NCH-1:0] ch_wr, ch_rd, ch_ibf, ch_obfn, ch_intr;
   logic [DW-1:0]  ch_pins [NCH];
   logic [DW-1:0]  ch_out  [NCH];
   logic [DW-1:0]  ch_inl  [NCH];

   ppio_bus_edge u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .rd_rise (rd_rise),
      .wr_rise (wr_rise)
   );

   assign cw_wr = wr_rise & (addr == SEL_CTL);
   assign pc_wr = wr_rise & (addr == SEL_PC);

   ppio_cfg #(.RESET_CW(RESET_CW)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .cw_wr    (cw_wr),
      .pc_wr    (pc_wr),
      .wdata    (d_in),
      .cfg_q    (cfg),
      .pc_lat   (pc_lat),
      .mode_set (mode_set)
   );

   // channel 0 is port A, channel 1 is port B
   assign ch_m1[0]     = cfg.a_m1;
   assign ch_in[0]     = cfg.a_in;
   assign ch_inte[0]   = cfg.a_in ? pc_lat[PC_STB_A] : pc_lat[PC_ACK_A];
   assign ch_sa_raw[0] = cfg.a_in ? pc_in[PC_STB_A] : pc_in[PC_ACK_A];
   assign ch_wr[0]     = wr_rise & (addr == SEL_PA);
   assign ch_rd[0]     = rd_rise & (addr == SEL_PA);
   assign ch_pins[0]   = pa_in;

   assign ch_m1[1]     = cfg.b_m1;
   assign ch_in[1]     = cfg.b_in;
   assign ch_inte[1]   = pc_lat[PC_STRB_B];
   assign ch_sa_raw[1] = pc_in[PC_STRB_B];
   assign ch_wr[1]     = wr_rise & (addr == SEL_PB);
   assign ch_rd[1]     = rd_rise & (addr == SEL_PB);
   assign ch_pins[1]   = pb_in;

   generate
      for (genvar g = 0; g < int'(NCH); g++) begin : g_ch
         ppio_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (ch_sa_raw[g]),
            .q     (ch_sa[g])
         );
         ppio_hs_chan #(.W(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (mode_set),
            .mode1    (ch_m1[g]),
            .is_input (ch_in[g]),
            .inte     (ch_inte[g]),
            .sa_n     (ch_sa[g]),
            .host_wr  (ch_wr[g]),
            .host_rd  (ch_rd[g]),
            .wdata    (d_in),
            .pins     (ch_pins[g]),
            .out_lat  (ch_out[g]),
            .in_lat   (ch_inl[g]),
            .ibf      (ch_ibf[g]),
            .obf_n    (ch_obfn[g]),
            .intr     (ch_intr[g])
         );
      end
   endgenerate

   assign pa_out = ch_out[0];
   assign pb_out = ch_out[1];
   assign pa_oe  = ~cfg.a_in;
   assign pb_oe  = ~cfg.b_in;

   // port C ownership: general halves first, handshake lines override
   always_comb begin
      logic half_in;
      for (int i = 0; i < int'(DW); i++) begin
         half_in   = (i >= 4) ? cfg.cu_in : cfg.cl_in;
         pc_out[i] = pc_lat[i];
         pc_oe[i]  = ~half_in;
         pc_rd[i]  = half_in ? pc_in[i] : pc_lat[i];
      end
      if (cfg.a_m1) begin
         pc_out[PC_INTR_A] = ch_intr[0];
         pc_oe[PC_INTR_A]  = 1'b1;
         pc_rd[PC_INTR_A]  = ch_intr[0];
         if (cfg.a_in) begin
            pc_oe[PC_STB_A]  = 1'b0;
            pc_rd[PC_STB_A]  = pc_lat[PC_STB_A];
            pc_out[PC_IBF_A] = ch_ibf[0];
            pc_oe[PC_IBF_A]  = 1'b1;
            pc_rd[PC_IBF_A]  = ch_ibf[0];
         end else begin
            pc_oe[PC_ACK_A]  = 1'b0;
            pc_rd[PC_ACK_A]  = pc_lat[PC_ACK_A];
            pc_out[PC_OBF_A] = ch_obfn[0];
            pc_oe[PC_OBF_A]  = 1'b1;
            pc_rd[PC_OBF_A]  = ch_obfn[0];
         end
      end
      if (cfg.b_m1) begin
         pc_out[PC_INTR_B] = ch_intr[1];
         pc_oe[PC_INTR_B]  = 1'b1;
         pc_rd[PC_INTR_B]  = ch_intr[1];
         pc_out[PC_FLAG_B] = cfg.b_in ? ch_ibf[1] : ch_obfn[1];
         pc_oe[PC_FLAG_B]  = 1'b1;
         pc_rd[PC_FLAG_B]  = cfg.b_in ? ch_ibf[1] : ch_obfn[1];
         pc_oe[PC_STRB_B]  = 1'b0;
         pc_rd[PC_STRB_B]  = pc_lat[PC_STRB_B];
      end
   end

   always_comb begin
      unique case (addr)
         SEL_PA:  d_out = cfg.a_in ? (cfg.a_m1 ? ch_inl[0] : pa_in) : ch_out[0];
         SEL_PB:  d_out = cfg.b_in ? (cfg.b_m1 ? ch_inl[1] : pb_in) : ch_out[1];
         SEL_PC:  d_out = pc_rd;
         default: d_out = '0;
      endcase
   end

   assign d_oe = ~rd_n;

   // R6
   modeset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && d_in[7] && !d_in[6]) |=> ((pa_out == '0) && (pb_out == '0)));

   // R3
   oe_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cw_wr && d_in[7] && !d_in[6]) |=> ((pa_oe == !$past(d_in[4])) && (pb_oe == !$past(d_in[1]))));

   // R1
   ctl_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && (addr == SEL_CTL)) |-> (d_out == '0));

endmodule

// File: tb/ppio_top_tb.sv
module ppio_top_tb;
   localparam int unsigned SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] d_in = 8'h00;
   logic [7:0] d_out;
   logic       d_oe;
   logic [7:0] pa_in = 8'h00;
   logic [7:0] pa_out;
   logic       pa_oe;
   logic [7:0] pb_in = 8'h00;
   logic [7:0] pb_out;
   logic       pb_oe;
   logic [7:0] pc_in = 8'hFF;
   logic [7:0] pc_out;
   logic [7:0] pc_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ppio_top #(.SYNC_STAGES(SYNC), .RESET_CW(8'h9B)) u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
      .d_in(d_in), .d_out(d_out), .d_oe(d_oe),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; d_in = d; wr_n = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic host_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
      @(negedge clk);
      addr = a; rd_n = 1'b0;
      #1;
      d = d_out; oe = d_oe;
      @(negedge clk);
      rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic pulse_pc(input int b);
      @(negedge clk);
      pc_in[b] = 1'b0;
      repeat (SYNC + 2) @(negedge clk);
      pc_in[b] = 1'b1;
      repeat (SYNC + 2) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v; logic oe;
      chk("R2 pa_oe", {7'd0, pa_oe}, 8'h00);
      chk("R2 pb_oe", {7'd0, pb_oe}, 8'h00);
      chk("R2 pc_oe", pc_oe, 8'h00);
      chk("R2 pc_out", pc_out, 8'h00);
      chk("R1 d_oe idle", {7'd0, d_oe}, 8'h00);
      pb_in = 8'h5C;
      host_rd(2'd1, v, oe);
      chk("R2 read B pins", v, 8'h5C);
      chk("R1 d_oe during read", {7'd0, oe}, 8'h01);
   endtask

   task automatic t_mode0();
      logic [7:0] v; logic oe;
      host_wr(2'd3, 8'h80);
      chk("R3 0x80 pa_oe", {7'd0, pa_oe}, 8'h01);
      chk("R3 0x80 pb_oe", {7'd0, pb_oe}, 8'h01);
      chk("R3 0x80 pc_oe", pc_oe, 8'hFF);
      host_wr(2'd0, 8'h5A);
      host_wr(2'd1, 8'hC3);
      host_wr(2'd2, 8'h3C);
      chk("R4 pa_out", pa_out, 8'h5A);
      chk("R4 pb_out", pb_out, 8'hC3);
      chk("R4 pc_out", pc_out, 8'h3C);
      host_rd(2'd0, v, oe);
      chk("R4 read A latch", v, 8'h5A);
      host_rd(2'd2, v, oe);
      chk("R4 read C latch", v, 8'h3C);
      host_wr(2'd3, 8'h98);
      chk("R3 0x98 pa_oe", {7'd0, pa_oe}, 8'h00);
      chk("R3 0x98 pb_oe", {7'd0, pb_oe}, 8'h01);
      chk("R3 0x98 pc_oe", pc_oe, 8'h0F);
      chk("R6 pb_out cleared", pb_out, 8'h00);
      chk("R6 pc_out cleared", pc_out, 8'h00);
      pa_in = 8'h6E;
      host_rd(2'd0, v, oe);
      chk("R4 read A pins", v, 8'h6E);
      pc_in = 8'hAF;
      host_rd(2'd2, v, oe);
      chk("R4 read C mixed halves", v, 8'hA0);
      pc_in = 8'hFF;
      host_rd(2'd3, v, oe);
      chk("R1 control read", v, 8'h00);
   endtask

   task automatic t_bsr();
      host_wr(2'd3, 8'h80);
      host_wr(2'd3, 8'h09);
      chk("R5 set bit4", pc_out, 8'h10);
      host_wr(2'd3, 8'h0F);
      chk("R5 set bit7", pc_out, 8'h90);
      host_wr(2'd3, 8'h08);
      chk("R5 clear bit4", pc_out, 8'h80);
      chk("R5 config kept", {7'd0, pa_oe}, 8'h01);
   endtask

   task automatic t_mode2();
      host_wr(2'd3, 8'h80);
      host_wr(2'd0, 8'h11);
      host_wr(2'd2, 8'h22);
      host_wr(2'd3, 8'hC0);
      chk("R7 pa_out kept", pa_out, 8'h11);
      chk("R7 pc_out kept", pc_out, 8'h22);
      chk("R7 pa_oe kept", {7'd0, pa_oe}, 8'h01);
      chk("R7 pc_oe kept", pc_oe, 8'hFF);
   endtask

   task automatic t_in_a();
      logic [7:0] v; logic oe;
      host_wr(2'd3, 8'hB0);
      chk("R8 pc_oe", pc_oe, 8'hEF);
      chk("R8 idle flags", pc_out, 8'h00);
      pa_in = 8'hA5;
      pulse_pc(4);
      pa_in = 8'h00;
      chk("R8 ibf set", {7'd0, pc_out[5]}, 8'h01);
      chk("R12 no intr without enable", {7'd0, pc_out[3]}, 8'h00);
      host_rd(2'd2, v, oe);
      chk("R13 read C input A", v, 8'h20);
      host_rd(2'd0, v, oe);
      chk("R8 read A latched", v, 8'hA5);
      chk("R8 ibf cleared", {7'd0, pc_out[5]}, 8'h00);
      host_wr(2'd3, 8'h09);
      pa_in = 8'h3C;
      pulse_pc(4);
      pa_in = 8'h00;
      chk("R12 intr A in", {7'd0, pc_out[3]}, 8'h01);
      host_rd(2'd2, v, oe);
      chk("R13 read C with enable", v, 8'h38);
      host_rd(2'd0, v, oe);
      chk("R8 read A second", v, 8'h3C);
      chk("R12 intr A falls", {7'd0, pc_out[3]}, 8'h00);
   endtask

   task automatic t_in_b();
      logic [7:0] v; logic oe;
      host_wr(2'd3, 8'h86);
      chk("R9 pc_oe", pc_oe, 8'hFB);
      chk("R9 pb_oe", {7'd0, pb_oe}, 8'h00);
      host_wr(2'd3, 8'h05);
      pb_in = 8'h77;
      pulse_pc(2);
      pb_in = 8'h00;
      chk("R9 ibf B", {7'd0, pc_out[1]}, 8'h01);
      chk("R12 intr B", {7'd0, pc_out[0]}, 8'h01);
      host_rd(2'd2, v, oe);
      chk("R13 read C input B", v, 8'h07);
      host_rd(2'd1, v, oe);
      chk("R9 read B latched", v, 8'h77);
      chk("R9 ibf/intr B cleared", {6'd0, pc_out[1:0]}, 8'h00);
   endtask

   task automatic t_out_a();
      logic [7:0] v; logic oe;
      host_wr(2'd3, 8'hA0);
      chk("R10 pc_oe", pc_oe, 8'hBF);
      chk("R10 obf idle high", {7'd0, pc_out[7]}, 8'h01);
      host_wr(2'd3, 8'h0D);
      host_wr(2'd0, 8'h99);
      chk("R10 pa_out", pa_out, 8'h99);
      chk("R10 obf low", {7'd0, pc_out[7]}, 8'h00);
      chk("R12 intr low while full", {7'd0, pc_out[3]}, 8'h00);
      pulse_pc(6);
      chk("R10 obf released", {7'd0, pc_out[7]}, 8'h01);
      chk("R12 intr A out", {7'd0, pc_out[3]}, 8'h01);
      host_rd(2'd2, v, oe);
      chk("R13 read C output A", v, 8'hC8);
      host_wr(2'd0, 8'h12);
      chk("R12 intr cleared by write", {7'd0, pc_out[3]}, 8'h00);
      chk("R10 obf low again", {7'd0, pc_out[7]}, 8'h00);
      host_wr(2'd3, 8'h80);
      chk("R6 pa_out cleared", pa_out, 8'h00);
      chk("R6 pc_out cleared", pc_out, 8'h00);
   endtask

   task automatic t_out_b();
      logic [7:0] v; logic oe;
      host_wr(2'd3, 8'h84);
      chk("R11 pc_oe", pc_oe, 8'hFB);
      host_wr(2'd1, 8'h42);
      chk("R11 pb_out", pb_out, 8'h42);
      chk("R11 obf B low", {7'd0, pc_out[1]}, 8'h00);
      pulse_pc(2);
      chk("R11 obf B released", {7'd0, pc_out[1]}, 8'h01);
      chk("R12 intr B gated", {7'd0, pc_out[0]}, 8'h00);
      host_rd(2'd2, v, oe);
      chk("R13 read C output B", v, 8'h02);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mode0();
      t_bsr();
      t_mode2();
      t_in_a();
      t_in_b();
      t_out_a();
      t_out_b();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule